// File: doc/BRIEF.md
# Floating-Point Triplet Scheduler Queue

This block buffers floating-point macro-ops between decode and the three execution pipes. A group of up to three macro-ops arrives on the allocate port. Each slot has a valid bit, a pipe-kind code, a tag and an optional pair-link bit. The queue keeps the groups in arrival order. When the two oldest partly filled groups fit together, it folds them into one group so that storage is freed for new allocations.

Every cycle, each of the three pipes (add, multiply, auxiliary/store) takes at most one macro-op. The choice uses only the pipe-kind code, never the slot position, and goes to the oldest ready one. Readiness comes from a scoreboard vector indexed by tag. A 128-bit vector operation is split into two macro-ops for the same pipe. The second one carries the link bit, and the queue holds it until it has become the oldest waiting entry of its pipe. This makes the two halves issue in order and on different cycles.

Top module: `fp_triplet_sched`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, iss_valid_o is 0 and full_o is 0. The queue holds no entries.
- R2: The queue holds at most 12 groups of 3 slots. full_o is high exactly when 12 groups are still occupied after this cycle's issue clears, group freeing and group folding. While full_o is high, an allocation is ignored and none of its macro-ops is ever issued.
- R3: An allocation is accepted when alloc_valid_i is 1, alloc_mask_i is non-zero and full_o is 0. It becomes the youngest group. An allocation with a zero mask has no effect.
- R4: Pipe-kind code 0 is add, 1 is multiply and 2 is auxiliary/store. Slot s of an allocation uses alloc_unit_i[2s+1:2s] and alloc_tag_i[6s+5:6s]. iss_valid_o[u] and iss_tag_o[6u+5:6u] belong to pipe u. Each pipe issues at most one macro-op per cycle, and only one whose code matches the pipe, from any slot position.
- R5: Among the valid entries of a pipe's kind whose ready_i[tag] bit is 1, the oldest one is issued. Age orders by group arrival first and slot index second.
- R6: An entry with its link bit set (alloc_link_i[s]) is issued only when no older valid entry of the same pipe kind remains. Its lower half therefore issues on an earlier cycle.
- R7: An issued macro-op is removed at the next rising clock edge and is never issued again.
- R8: After issue clears and group freeing, take the oldest partly filled group (1 or 2 entries). If the next group in age is also partly filled and the two together hold at most 3 entries, they are folded into the older group's position. The older group's entries come first, then the younger group's, each in slot order. The younger group is freed.
- R9: A group with no valid slot left is freed in the same cycle. Younger groups close the gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_mask_i | input | 3 | Valid bit per slot |
| alloc_link_i | input | 3 | Second-half-of-pair bit per slot |
| alloc_unit_i | input | 6 | Pipe-kind code per slot, 2 bits each |
| alloc_tag_i | input | 18 | Tag per slot, 6 bits each |
| ready_i | input | 64 | Ready bit per tag |
| full_o | output | 1 | No free group; allocation refused |
| iss_valid_o | output | 3 | Issue valid per pipe |
| iss_tag_o | output | 18 | Issued tag per pipe, 6 bits each |

## Verification
The sharpest collision is an issue that empties a slot in the same cycle that folding or group freeing must account for. This matters most when the queue is near capacity and an allocation is also pending. full_o must then reflect the post-issue, post-fold occupancy, and no more. The bench provokes this in two ways. It pairs directed fills of 12 groups with a single-entry allocation stream that only survives by folding. It also runs long random phases with sparse ready bits, which keep the queue full and partly drained. A bench model steps the same rules each cycle and compares every issue tag and full_o against them. It also checks that stalled link halves and refused groups never appear at the issue ports.

// File: rtl/fpq_pkg.sv
package fpq_pkg;
  localparam int TAG_W     = 6;
  localparam int GRP_SLOTS = 3;
  localparam int NUM_UNITS = 3;

  typedef enum logic [1:0] {
    UNIT_ADD  = 2'd0,
    UNIT_MUL  = 2'd1,
    UNIT_MISC = 2'd2,
    UNIT_NONE = 2'd3
  } unit_e;

  typedef struct packed {
    logic             vld;
    logic             link;
    unit_e            unit;
    logic [TAG_W-1:0] tag;
  } entry_t;

  typedef entry_t [GRP_SLOTS-1:0] group_t;

  function automatic logic [1:0] grp_fill(group_t g);
    logic [1:0] n;
    n = '0;
    for (int s = 0; s < GRP_SLOTS; s++) n = n + {1'b0, g[s].vld};
    return n;
  endfunction
endpackage

// File: rtl/fpq_pick.sv
module fpq_pick #(
  parameter int N  = 36,
  parameter int IW = 6
) (
  input  logic [N-1:0]  req_i,
  output logic          gnt_vld_o,
  output logic [IW-1:0] gnt_idx_o
);
  // lowest index = oldest
  always_comb begin
    gnt_vld_o = 1'b0;
    gnt_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_vld_o = 1'b1;
        gnt_idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/fpq_compact.sv
module fpq_compact
  import fpq_pkg::*;
#(
  parameter int NUM_GROUPS = 12,
  parameter int CW         = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  group_t [NUM_GROUPS-1:0]  grp_i,
  output group_t [NUM_GROUPS-1:0]  grp_o,
  output logic [CW-1:0]            cnt_o
);
  logic [CW-1:0] k;

  always_comb begin
    grp_o = '0;
    k     = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_fill(grp_i[g]) != 2'd0) begin
        grp_o[k] = grp_i[g];
        k        = k + CW'(1);
      end
    end
    cnt_o = k;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    assert_packed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (CW'(g) < cnt_o) == (grp_fill(grp_o[g]) != 2'd0));
  end
endmodule

// File: rtl/fpq_merge.sv
module fpq_merge
  import fpq_pkg::*;
#(
  parameter int NUM_GROUPS = 12,
  parameter int CW         = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  group_t [NUM_GROUPS-1:0]  grp_i,
  input  logic [CW-1:0]            cnt_i,
  output group_t [NUM_GROUPS-1:0]  grp_o,
  output logic [CW-1:0]            cnt_o
);
  localparam int NE = NUM_GROUPS * GRP_SLOTS;
  localparam int LW = $clog2(NE + 1);

  int                   pi;
  int                   k;
  group_t               lo, hi, mrg;
  entry_t [2*GRP_SLOTS-1:0] src;
  logic [1:0]           f_lo, f_hi;
  logic                 do_merge;

  always_comb begin
    pi = -1;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (pi < 0 && g < int'(cnt_i) &&
          grp_fill(grp_i[g]) != 2'd0 && grp_fill(grp_i[g]) != 2'd3) pi = g;
    end
    lo = '0;
    hi = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (g == pi)     lo = grp_i[g];
      if (g == pi + 1) hi = grp_i[g];
    end
    f_lo = grp_fill(lo);
    f_hi = grp_fill(hi);
    do_merge = (pi >= 0) && (pi + 1 < int'(cnt_i)) &&
               (f_hi != 2'd0) && (f_hi != 2'd3) &&
               ({1'b0, f_lo} + {1'b0, f_hi} <= 3'd3);
    // older entries first, slot order kept
    src = {hi, lo};
    mrg = '0;
    k   = 0;
    for (int i = 0; i < 2 * GRP_SLOTS; i++) begin
      if (src[i].vld) begin
        for (int d = 0; d < GRP_SLOTS; d++) if (d == k) mrg[d] = src[i];
        k++;
      end
    end
    for (int g = 0; g < NUM_GROUPS - 1; g++) begin
      if (do_merge && g == pi)     grp_o[g] = mrg;
      else if (do_merge && g > pi) grp_o[g] = grp_i[g+1];
      else                         grp_o[g] = grp_i[g];
    end
    grp_o[NUM_GROUPS-1] = do_merge ? '0 : grp_i[NUM_GROUPS-1];
    cnt_o = cnt_i - CW'(do_merge);
  end

  logic [LW-1:0] n_in, n_out;
  always_comb begin
    n_in  = '0;
    n_out = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      n_in  = n_in  + LW'(grp_fill(grp_i[g]));
      n_out = n_out + LW'(grp_fill(grp_o[g]));
    end
  end

  assert_fold_keeps_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_in == n_out);
endmodule

// File: rtl/fp_triplet_sched.sv
module fp_triplet_sched
  import fpq_pkg::*;
#(
  parameter int NUM_GROUPS = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         alloc_valid_i,
  input  logic [GRP_SLOTS-1:0]         alloc_mask_i,
  input  logic [GRP_SLOTS-1:0]         alloc_link_i,
  input  logic [2*GRP_SLOTS-1:0]       alloc_unit_i,
  input  logic [TAG_W*GRP_SLOTS-1:0]   alloc_tag_i,
  input  logic [(1<<TAG_W)-1:0]        ready_i,
  output logic                         full_o,
  output logic [NUM_UNITS-1:0]         iss_valid_o,
  output logic [TAG_W*NUM_UNITS-1:0]   iss_tag_o
);
  localparam int NE = NUM_GROUPS * GRP_SLOTS;
  localparam int IW = $clog2(NE);
  localparam int CW = $clog2(NUM_GROUPS + 1);
  localparam int LW = $clog2(NE + 1);

  group_t [NUM_GROUPS-1:0] grp_q, grp_d, grp_clr, grp_cmp, grp_mrg;
  logic [CW-1:0]           cnt_q, cnt_d, cnt_cmp, cnt_mrg;
  entry_t [NE-1:0]         ent, ent_clr;

  assign ent = grp_q;

  logic [NUM_UNITS-1:0][NE-1:0] req_first, req_iss;
  logic [NUM_UNITS-1:0]         first_vld, iss_vld;
  logic [NUM_UNITS-1:0][IW-1:0] first_idx, iss_idx;

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++)
      for (int e = 0; e < NE; e++)
        req_first[u][e] = ent[e].vld && (ent[e].unit == unit_e'(u));
  end

  // link half waits until it is the oldest of its kind
  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++)
      for (int e = 0; e < NE; e++)
        req_iss[u][e] = req_first[u][e] && ready_i[ent[e].tag] &&
                        (!ent[e].link || (first_vld[u] && first_idx[u] == IW'(e)));
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    fpq_pick #(.N(NE), .IW(IW)) u_first (
      .req_i     (req_first[u]),
      .gnt_vld_o (first_vld[u]),
      .gnt_idx_o (first_idx[u])
    );
    fpq_pick #(.N(NE), .IW(IW)) u_iss (
      .req_i     (req_iss[u]),
      .gnt_vld_o (iss_vld[u]),
      .gnt_idx_o (iss_idx[u])
    );
    assign iss_valid_o[u]                 = iss_vld[u];
    assign iss_tag_o[u*TAG_W +: TAG_W]    = iss_vld[u] ? ent[iss_idx[u]].tag : '0;
  end

  always_comb begin
    ent_clr = ent;
    for (int u = 0; u < NUM_UNITS; u++)
      if (iss_vld[u]) ent_clr[iss_idx[u]].vld = 1'b0;
  end
  assign grp_clr = ent_clr;

  fpq_compact #(.NUM_GROUPS(NUM_GROUPS), .CW(CW)) u_compact (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .grp_i  (grp_clr),
    .grp_o  (grp_cmp),
    .cnt_o  (cnt_cmp)
  );

  fpq_merge #(.NUM_GROUPS(NUM_GROUPS), .CW(CW)) u_merge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .grp_i  (grp_cmp),
    .cnt_i  (cnt_cmp),
    .grp_o  (grp_mrg),
    .cnt_o  (cnt_mrg)
  );

  logic   alloc_take;
  group_t new_grp;

  assign full_o     = (cnt_mrg == CW'(NUM_GROUPS));
  assign alloc_take = alloc_valid_i && (|alloc_mask_i) && !full_o;

  always_comb begin
    for (int s = 0; s < GRP_SLOTS; s++) begin
      new_grp[s].vld  = alloc_mask_i[s];
      new_grp[s].link = alloc_link_i[s] && alloc_mask_i[s];
      new_grp[s].unit = unit_e'(alloc_unit_i[2*s +: 2]);
      new_grp[s].tag  = alloc_tag_i[s*TAG_W +: TAG_W];
    end
    grp_d = grp_mrg;
    if (alloc_take) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (CW'(g) == cnt_mrg) grp_d[g] = new_grp;
    end
    cnt_d = cnt_mrg + CW'(alloc_take);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      cnt_q <= '0;
    end else begin
      grp_q <= grp_d;
      cnt_q <= cnt_d;
    end
  end

  logic [LW-1:0] live_cnt, n_iss, n_new;
  always_comb begin
    live_cnt = '0;
    for (int e = 0; e < NE; e++) live_cnt = live_cnt + LW'(ent[e].vld);
    n_iss = LW'($countones(iss_valid_o));
    n_new = alloc_take ? LW'($countones(alloc_mask_i)) : '0;
  end

  assert_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NUM_GROUPS));

  assert_issue_retire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_cnt == $past(live_cnt) - $past(n_iss) + $past(n_new));

  assert_one_per_pipe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(iss_valid_o) <= live_cnt);
endmodule

// File: tb/fp_triplet_sched_tb.sv
`timescale 1ns/1ps
module fp_triplet_sched_tb;
  localparam int NG = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [2:0]  alloc_mask_i = '0;
  logic [2:0]  alloc_link_i = '0;
  logic [5:0]  alloc_unit_i = '0;
  logic [17:0] alloc_tag_i = '0;
  logic [63:0] ready_i = '0;
  logic        full_o;
  logic [2:0]  iss_valid_o;
  logic [17:0] iss_tag_o;

  always #2 clk = ~clk;

  fp_triplet_sched u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .alloc_valid_i(alloc_valid_i),
    .alloc_mask_i(alloc_mask_i), .alloc_link_i(alloc_link_i),
    .alloc_unit_i(alloc_unit_i), .alloc_tag_i(alloc_tag_i), .ready_i(ready_i),
    .full_o(full_o), .iss_valid_o(iss_valid_o), .iss_tag_o(iss_tag_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model
  bit mv[NG][3], ml[NG][3], nv[NG][3], nl[NG][3], cv[NG][3], cl[NG][3];
  int mu[NG][3], mt[NG][3], nu[NG][3], nt[NG][3], cu[NG][3], ct[NG][3];
  int mcnt = 0, ncnt;
  bit live[64];
  bit exp_iv[3];
  int exp_tag[3];
  bit exp_full;
  bit obs_iv[3];
  int obs_tag[3];
  bit obs_full;

  function automatic int fillc(bit a, bit b, bit c);
    return int'(a) + int'(b) + int'(c);
  endfunction

  task automatic model_eval(bit [63:0] rdy);
    int first, pick, k, p, f1, f2, j;
    bit sv[6], sl[6];
    int su[6], st[6];
    for (int g = 0; g < NG; g++)
      for (int s = 0; s < 3; s++) begin
        cv[g][s] = mv[g][s]; cl[g][s] = ml[g][s]; cu[g][s] = mu[g][s]; ct[g][s] = mt[g][s];
      end
    for (int u = 0; u < 3; u++) begin
      exp_iv[u] = 0; exp_tag[u] = 0; first = -1; pick = -1;
      for (int e = 0; e < NG*3; e++) begin
        if (mv[e/3][e%3] && mu[e/3][e%3] == u) begin
          if (first < 0) first = e;
          if (pick < 0 && rdy[mt[e/3][e%3]] && (!ml[e/3][e%3] || e == first)) pick = e;
        end
      end
      if (pick >= 0) begin
        exp_iv[u] = 1; exp_tag[u] = mt[pick/3][pick%3]; cv[pick/3][pick%3] = 0;
      end
    end
    for (int g = 0; g < NG; g++)
      for (int s = 0; s < 3; s++) begin
        nv[g][s] = 0; nl[g][s] = 0; nu[g][s] = 0; nt[g][s] = 0;
      end
    k = 0;
    for (int g = 0; g < NG; g++) begin
      if (cv[g][0] || cv[g][1] || cv[g][2]) begin
        for (int s = 0; s < 3; s++) begin
          nv[k][s] = cv[g][s]; nl[k][s] = cl[g][s]; nu[k][s] = cu[g][s]; nt[k][s] = ct[g][s];
        end
        k++;
      end
    end
    p = -1;
    for (int g = 0; g < k; g++) begin
      f1 = fillc(nv[g][0], nv[g][1], nv[g][2]);
      if (p < 0 && f1 >= 1 && f1 <= 2) p = g;
    end
    if (p >= 0 && p + 1 < k) begin
      f1 = fillc(nv[p][0], nv[p][1], nv[p][2]);
      f2 = fillc(nv[p+1][0], nv[p+1][1], nv[p+1][2]);
      if (f2 >= 1 && f2 <= 2 && f1 + f2 <= 3) begin
        j = 0;
        for (int h = 0; h < 2; h++)
          for (int s = 0; s < 3; s++)
            if (nv[p+h][s]) begin
              sv[j] = 1; sl[j] = nl[p+h][s]; su[j] = nu[p+h][s]; st[j] = nt[p+h][s]; j++;
            end
        for (int d = 0; d < 3; d++) begin
          nv[p][d] = (d < j); nl[p][d] = (d < j) ? sl[d] : 0;
          nu[p][d] = (d < j) ? su[d] : 0; nt[p][d] = (d < j) ? st[d] : 0;
        end
        for (int g = p + 1; g < k - 1; g++)
          for (int s = 0; s < 3; s++) begin
            nv[g][s] = nv[g+1][s]; nl[g][s] = nl[g+1][s]; nu[g][s] = nu[g+1][s]; nt[g][s] = nt[g+1][s];
          end
        for (int s = 0; s < 3; s++) begin
          nv[k-1][s] = 0; nl[k-1][s] = 0; nu[k-1][s] = 0; nt[k-1][s] = 0;
        end
        k--;
      end
    end
    exp_full = (k == NG);
    ncnt = k;
  endtask

  task automatic step(bit av, bit [2:0] am, bit [2:0] al, bit [5:0] aun,
                      bit [17:0] atag, bit [63:0] rdy);
    bit acc;
    @(negedge clk);
    alloc_valid_i = av; alloc_mask_i = am; alloc_link_i = al;
    alloc_unit_i = aun; alloc_tag_i = atag; ready_i = rdy;
    #1;
    model_eval(rdy);
    for (int u = 0; u < 3; u++) begin
      obs_iv[u]  = iss_valid_o[u];
      obs_tag[u] = int'(iss_tag_o[u*6 +: 6]);
      chk(obs_iv[u] == exp_iv[u], $sformatf("R4 valid pipe %0d", u), obs_iv[u], exp_iv[u]);
      if (obs_iv[u] && exp_iv[u])
        chk(obs_tag[u] == exp_tag[u], $sformatf("R5 tag pipe %0d", u), obs_tag[u], exp_tag[u]);
    end
    obs_full = full_o;
    chk(obs_full == exp_full, "R2 full", obs_full, exp_full);
    acc = av && (am != 0) && !exp_full;
    @(posedge clk);
    for (int u = 0; u < 3; u++) if (exp_iv[u]) live[exp_tag[u]] = 0;
    if (acc) begin
      for (int s = 0; s < 3; s++) begin
        nv[ncnt][s] = am[s]; nl[ncnt][s] = al[s] & am[s];
        nu[ncnt][s] = int'(aun[2*s +: 2]); nt[ncnt][s] = int'(atag[6*s +: 6]);
        if (am[s]) live[atag[6*s +: 6]] = 1;
      end
      ncnt++;
    end
    for (int g = 0; g < NG; g++)
      for (int s = 0; s < 3; s++) begin
        mv[g][s] = nv[g][s]; ml[g][s] = nl[g][s]; mu[g][s] = nu[g][s]; mt[g][s] = nt[g][s];
      end
    mcnt = ncnt;
  endtask

  task automatic idle(int n, bit [63:0] rdy);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, rdy);
  endtask

  task automatic rand_step();
    bit av; bit [2:0] am, al; bit [5:0] aun; bit [17:0] atag;
    bit used[64]; int t;
    bit [63:0] rdy;
    av = ($urandom % 4) != 0;
    am = 3'($urandom % 8);
    al = '0; aun = '0; atag = '0;
    for (int i = 0; i < 64; i++) used[i] = live[i];
    for (int s = 0; s < 3; s++) begin
      aun[2*s +: 2] = 2'($urandom % 3);
      if (s > 0 && am[s] && am[s-1] && ($urandom % 4) == 0) begin
        al[s] = 1; aun[2*s +: 2] = aun[2*(s-1) +: 2];
      end
      t = int'($urandom % 64);
      while (used[t]) t = (t + 1) % 64;
      used[t] = 1;
      atag[6*s +: 6] = 6'(t);
    end
    rdy = {$urandom, $urandom} & {$urandom, $urandom};
    step(av, am, al, aun, atag, rdy);
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seen, nxt;
    bit order_ok;
    void'($urandom(32'h5eed));
    // R1
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(iss_valid_o == 3'b000, "R1 issue in reset", int'(iss_valid_o), 0);
    chk(full_o == 1'b0, "R1 full in reset", int'(full_o), 0);
    ready_i = '1;
    #1;
    chk(iss_valid_o == 3'b000, "R1 ready in reset", int'(iss_valid_o), 0);
    rst_ni = 1'b1;
    idle(1, '1);
    chk(obs_iv[0] == 0 && obs_iv[1] == 0 && obs_iv[2] == 0, "R1 empty after reset", int'(obs_iv[0]), 0);

    // R3 zero mask is ignored
    step(1, 3'b000, 0, 6'b000000, {6'd7, 6'd6, 6'd5}, '1);
    idle(1, '1);
    chk(!obs_iv[0] && !obs_iv[1] && !obs_iv[2], "R3 zero mask queued nothing", int'(obs_iv[0]), 0);

    // R6 pair on add pipe: tag 1 lower, tag 2 link
    step(1, 3'b011, 3'b010, 6'b000000, {6'd0, 6'd2, 6'd1}, '0);
    idle(1, 64'h4);
    chk(!obs_iv[0], "R6 link held behind lower half", int'(obs_iv[0]), 0);
    idle(1, 64'h6);
    chk(obs_iv[0] && obs_tag[0] == 1, "R6 lower half first", obs_tag[0], 1);
    idle(1, 64'h6);
    chk(obs_iv[0] && obs_tag[0] == 2, "R6 link half next cycle", obs_tag[0], 2);
    idle(1, 64'h6);
    chk(!obs_iv[0], "R7 no reissue", int'(obs_iv[0]), 0);

    // R2 fill 12 full groups, then refused allocation
    for (int g = 0; g < 12; g++)
      step(1, 3'b111, 0, {2'(g % 3), 2'((g + 1) % 3), 2'((g + 2) % 3)},
           {6'(3 + 3*g + 2), 6'(3 + 3*g + 1), 6'(3 + 3*g)}, '0);
    step(1, 3'b111, 0, 6'b100100, {6'd42, 6'd41, 6'd40}, '0);
    chk(obs_full, "R2 full at 12 groups", int'(obs_full), 1);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      idle(1, '1);
      for (int u = 0; u < 3; u++) begin
        if (obs_iv[u]) seen++;
        if (obs_iv[u]) chk(obs_tag[u] < 40, "R2 refused group issued", obs_tag[u], 0);
      end
    end
    chk(seen == 36, "R2 only queued ops drained", seen, 36);

    // R9 freed groups reusable
    for (int g = 0; g < 11; g++)
      step(1, 3'b111, 0, 6'b100100, {6'(3*g + 2), 6'(3*g + 1), 6'(3*g)}, '0);
    idle(1, '0);
    chk(!obs_full, "R9 groups freed and reused", int'(obs_full), 0);
    idle(20, '1);

    // R8 single-entry groups must fold to fit
    for (int i = 0; i < 16; i++) begin
      step(1, 3'b001, 0, 6'b000001, {12'd0, 6'(i)}, '0);
      chk(!obs_full, "R8 folding keeps space", int'(obs_full), 0);
    end
    nxt = 0; order_ok = 1;
    for (int i = 0; i < 20; i++) begin
      idle(1, '1);
      if (obs_iv[1]) begin
        if (obs_tag[1] != nxt) order_ok = 0;
        nxt++;
      end
    end
    chk(order_ok && nxt == 16, "R8 fold keeps age order", nxt, 16);

    // random mix
    for (int i = 0; i < 4000; i++) rand_step();
    idle(40, '1);
    chk(mcnt == 0, "R7 queue drained", mcnt, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule